// File: doc/BRIEF.md
# Dual-Width Accumulator ALU for a Packet-Filter Machine

This block is the execution unit of a small packet-filter virtual machine. The destination register value is the first operand, and the result replaces it, as in an accumulator. The second operand is either a source register value or a signed 32-bit immediate. Each of thirteen operations can run in a full 64-bit mode or in a 32-bit mode. The 32-bit mode uses only the low halves of the operands and clears the upper half of the result.

A request is presented with a one-cycle `start` strobe. All operations except divide and remainder complete at the next clock edge. Unsigned divide and remainder use an iterative restoring divider that retires one quotient bit per cycle. While it runs the unit is busy and ignores new requests. A one-cycle `done` pulse marks each finished result. `result` holds that value until the next completion, so the surrounding pipeline writes it back to the destination register.

Top module: `pf_alu`

## Requirements
- R1: `op` codes are: 0 add, 1 subtract, 2 multiply (low 64/32 bits), 3 unsigned divide, 4 unsigned remainder, 5 AND, 6 OR, 7 XOR, 8 left shift, 9 logical right shift, 10 arithmetic right shift, 11 negate, 12 move; codes 13 to 15 return the destination operand (width-adjusted).
- R2: The first operand is `dst_val`, and for every operation other than divide and remainder with a nonzero divisor, `result` and a `done` pulse appear at the clock edge that accepts `start`.
- R3: With `use_imm`=1 the second operand is `imm` sign-extended to 64 bits; with `use_imm`=0 it is `src_val`.
- R4: With `wide`=0 only bits 31:0 of both operands are used, and `result[63:32]` is zero; with `wide`=1 all 64 bits are used.
- R5: The shift count is the second operand's bits 5:0 in 64-bit mode and bits 4:0 in 32-bit mode. Arithmetic right shift copies bit 63 (64-bit) or bit 31 (32-bit) into the vacated bits.
- R6: Negate returns the two's complement of the destination operand and ignores the second operand; move returns the second operand.
- R7: Divide returns the unsigned quotient and remainder returns the unsigned remainder of destination by second operand.
- R8: For a nonzero divisor, `result` and `done` appear 64 clock edges (64-bit mode) or 32 clock edges (32-bit mode) after the edge that accepts `start`.
- R9: A zero divisor (zero after the width mask of R4) completes in one cycle as in R2. Divide then gives 0, and remainder gives the width-adjusted destination operand.
- R10: After reset `result`=0 and `done`=0. `done` is high for exactly one cycle per completed operation, and `result` changes only when `done` rises with it.
- R11: A `start` raised while the divider is busy is ignored: it yields no completion and does not alter the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| op | input | 4 | Operation code (R1) |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_imm | input | 1 | 1 = immediate as second operand |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate |
| result | output | 64 | Value to write back to the destination |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives each operation with operands chosen so that a wrong choice shows up in the result:
- Destination values have upper halves that a 32-bit operation must drop.
- Negative immediates separate sign extension from zero extension.
- Shift counts above 31 or 63 show whether the count is masked.
- Negative values under right shifts separate the logical shift from the arithmetic one.

Divide and remainder are tried in both widths with large operands and with zero divisors. The latency is counted in clock edges, so iteration count and zero-divisor bypass are measured directly. A request raised in the middle of a division checks that the pending quotient survives and that only one completion appears.

// File: rtl/pf_alu_pkg.sv
package pf_alu_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HALF_W = REG_W / 2;
  localparam int unsigned SH_W   = $clog2(REG_W);

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3,
    OP_MOD = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_XOR = 4'd7,
    OP_SHL = 4'd8, OP_SHR = 4'd9, OP_SAR = 4'd10, OP_NEG = 4'd11,
    OP_MOV = 4'd12
  } op_e;

  function automatic logic [REG_W-1:0] f_sext_imm(input logic [HALF_W-1:0] v);
    return {{HALF_W{v[HALF_W-1]}}, v};
  endfunction

  function automatic logic [REG_W-1:0] f_width(input logic [REG_W-1:0] v, input logic wide);
    return wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  // Single-cycle datapath; divide/remainder here only cover the zero-divisor case.
  function automatic logic [REG_W-1:0] f_fast(input op_e op, input logic wide,
                                              input logic [REG_W-1:0] a,
                                              input logic [REG_W-1:0] b);
    logic [REG_W-1:0]  r;
    logic [HALF_W-1:0] a32, b32, r32;
    logic [SH_W-1:0]   sh;
    logic [SH_W-2:0]   sh32;
    a32  = a[HALF_W-1:0];
    b32  = b[HALF_W-1:0];
    sh   = b[SH_W-1:0];
    sh32 = b[SH_W-2:0];
    r    = a;
    r32  = a32;
    if (wide) begin
      case (op)
        OP_ADD: r = a + b;
        OP_SUB: r = a - b;
        OP_MUL: r = a * b;
        OP_DIV: r = '0;
        OP_MOD: r = a;
        OP_AND: r = a & b;
        OP_OR:  r = a | b;
        OP_XOR: r = a ^ b;
        OP_SHL: r = a << sh;
        OP_SHR: r = a >> sh;
        OP_SAR: r = $unsigned($signed(a) >>> sh);
        OP_NEG: r = -a;
        OP_MOV: r = b;
        default: r = a;
      endcase
      return r;
    end
    case (op)
      OP_ADD: r32 = a32 + b32;
      OP_SUB: r32 = a32 - b32;
      OP_MUL: r32 = a32 * b32;
      OP_DIV: r32 = '0;
      OP_MOD: r32 = a32;
      OP_AND: r32 = a32 & b32;
      OP_OR:  r32 = a32 | b32;
      OP_XOR: r32 = a32 ^ b32;
      OP_SHL: r32 = a32 << sh32;
      OP_SHR: r32 = a32 >> sh32;
      OP_SAR: r32 = $unsigned($signed(a32) >>> sh32);
      OP_NEG: r32 = -a32;
      OP_MOV: r32 = b32;
      default: r32 = a32;
    endcase
    return {{HALF_W{1'b0}}, r32};
  endfunction
endpackage

// File: rtl/pf_alu_operand.sv
module pf_alu_operand
  import pf_alu_pkg::*;
(
  input  logic             wide,
  input  logic             use_imm,
  input  logic [REG_W-1:0] dst_val,
  input  logic [REG_W-1:0] src_val,
  input  logic [HALF_W-1:0] imm,
  output logic [REG_W-1:0] opa,
  output logic [REG_W-1:0] opb,
  output logic             b_zero
);
  logic [REG_W-1:0] b_raw;
  always_comb begin
    b_raw  = use_imm ? f_sext_imm(imm) : src_val;
    opa    = f_width(dst_val, wide);
    opb    = f_width(b_raw, wide);
    b_zero = (opb == '0);
  end
endmodule

// File: rtl/pf_alu_fast.sv
module pf_alu_fast
  import pf_alu_pkg::*;
(
  input  op_e              op,
  input  logic             wide,
  input  logic [REG_W-1:0] opa,
  input  logic [REG_W-1:0] opb,
  output logic [REG_W-1:0] res
);
  always_comb res = f_fast(op, wide, opa, opb);
endmodule

// File: rtl/pf_alu_divider.sv
module pf_alu_divider #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         want_rem,
  input  logic         wide,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] res
);
  localparam int unsigned H  = W / 2;
  localparam int unsigned CW = $clog2(W + 1);

  logic [W:0]    rem_q, shifted, rem_n;
  logic [W-1:0]  dvd_q, dsr_q, dvd_n;
  logic [CW-1:0] cnt_q;
  logic          rem_sel_q, wide_q, fits;

  always_comb begin
    shifted = {rem_q[W-1:0], dvd_q[W-1]};
    fits    = shifted >= {1'b0, dsr_q};
    rem_n   = fits ? shifted - {1'b0, dsr_q} : shifted;
    dvd_n   = {dvd_q[W-2:0], fits};
    finish  = busy && (cnt_q == CW'(1));
    if (rem_sel_q) res = rem_n[W-1:0];
    else           res = dvd_n;
    if (!wide_q)   res = {{H{1'b0}}, res[H-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      dvd_q     <= '0;
      dsr_q     <= '0;
      rem_sel_q <= 1'b0;
      wide_q    <= 1'b1;
    end else if (go && !busy) begin
      busy      <= 1'b1;
      cnt_q     <= wide ? CW'(W) : CW'(H);
      rem_q     <= '0;
      dvd_q     <= wide ? dividend : {dividend[H-1:0], {H{1'b0}}};
      dsr_q     <= divisor;
      rem_sel_q <= want_rem;
      wide_q    <= wide;
    end else if (busy) begin
      rem_q <= rem_n;
      dvd_q <= dvd_n;
      cnt_q <= cnt_q - CW'(1);
      if (finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_alu.sv
module pf_alu
  import pf_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic        wide,
  input  logic        use_imm,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  input  logic [31:0] imm,
  output logic [63:0] result,
  output logic        done
);
  op_e              op_q;
  logic [REG_W-1:0] opa, opb, fast_res, div_res;
  logic             b_zero, is_div, accept, div_go, fast_go;
  logic             div_busy, div_finish;

  assign op_q = op_e'(op);

  pf_alu_operand u_opnd (
    .wide(wide), .use_imm(use_imm), .dst_val(dst_val), .src_val(src_val),
    .imm(imm), .opa(opa), .opb(opb), .b_zero(b_zero)
  );

  pf_alu_fast u_fast (.op(op_q), .wide(wide), .opa(opa), .opb(opb), .res(fast_res));

  // Named event wires used by the bound checker.
  assign is_div  = (op_q == OP_DIV) || (op_q == OP_MOD);
  assign accept  = start && !div_busy;
  assign div_go  = accept && is_div && !b_zero;
  assign fast_go = accept && !div_go;

  pf_alu_divider #(.W(REG_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .want_rem(op_q == OP_MOD),
    .wide(wide), .dividend(opa), .divisor(opb),
    .busy(div_busy), .finish(div_finish), .res(div_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else if (div_finish) begin
      result <= div_res;
      done   <= 1'b1;
    end else if (fast_go) begin
      result <= fast_res;
      done   <= 1'b1;
    end else begin
      done   <= 1'b0;
    end
  end
endmodule

// File: rtl/pf_alu_checker.sv
module pf_alu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wide,
  input logic        done,
  input logic [63:0] result,
  input logic        accept,
  input logic        div_go,
  input logic        fast_go,
  input logic        div_busy,
  input logic        div_finish
);
  logic mode_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= 1'b1;
    else if (accept) mode_q <= wide;
  end

  a_r2_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
    fast_go |=> done);
  a_r8_quiet_while_dividing: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_finish) |=> !done);
  a_r11_div_takes_over: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |=> div_busy);
  a_r8_finish_releases: assert property (@(posedge clk) disable iff (!rst_n)
    div_finish |=> (done && !div_busy));
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (result[63:32] == 32'h0));
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind pf_alu pf_alu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wide(wide), .done(done), .result(result),
  .accept(accept), .div_go(div_go), .fast_go(fast_go),
  .div_busy(div_busy), .div_finish(div_finish)
);

// File: tb/tb_pf_alu.sv
module tb_pf_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'd0;
  logic        wide = 1'b1;
  logic        use_imm = 1'b0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm = '0;
  logic [63:0] result;
  logic        done;
  int          checks = 0, failures = 0;

  always #5 clk = ~clk;

  pf_alu dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
              .use_imm(use_imm), .dst_val(dst_val), .src_val(src_val), .imm(imm),
              .result(result), .done(done));

  // Independent reference model built from the requirements.
  function automatic logic [63:0] model(input logic [3:0] o, input logic w, input logic ui,
                                        input logic [63:0] d, input logic [63:0] s,
                                        input logic [31:0] im);
    logic [63:0] b, r, fill;
    logic [31:0] x, y, q;
    int          n;
    b = ui ? {{32{im[31]}}, im} : s;
    if (w) begin
      n = int'(b[5:0]);
      fill = d[63] ? ~(64'hFFFF_FFFF_FFFF_FFFF >> n) : 64'h0;
      case (o)
        4'd0: r = d + b;  4'd1: r = d + ~b + 64'd1;  4'd2: r = d * b;
        4'd3: r = (b == 0) ? 64'h0 : d / b;
        4'd4: r = (b == 0) ? d : d % b;
        4'd5: r = d & b;  4'd6: r = d | b;  4'd7: r = d ^ b;
        4'd8: r = d << n; 4'd9: r = d >> n; 4'd10: r = (d >> n) | fill;
        4'd11: r = 64'h0 - d; 4'd12: r = b;
        default: r = d;
      endcase
      return r;
    end
    x = d[31:0]; y = b[31:0]; n = int'(y[4:0]);
    case (o)
      4'd0: q = x + y;  4'd1: q = x + ~y + 32'd1;  4'd2: q = x * y;
      4'd3: q = (y == 0) ? 32'h0 : x / y;
      4'd4: q = (y == 0) ? x : x % y;
      4'd5: q = x & y;  4'd6: q = x | y;  4'd7: q = x ^ y;
      4'd8: q = x << n; 4'd9: q = x >> n;
      4'd10: q = (x >> n) | (x[31] ? ~(32'hFFFF_FFFF >> n) : 32'h0);
      4'd11: q = 32'h0 - x; 4'd12: q = y;
      default: q = x;
    endcase
    return {32'h0, q};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request; return edges counted until done is seen.
  task automatic run(input string tag, input logic [3:0] o, input logic w, input logic ui,
                     input logic [63:0] d, input logic [63:0] s, input logic [31:0] im,
                     input int exp_lat);
    int n;
    @(negedge clk);
    op = o; wide = w; use_imm = ui; dst_val = d; src_val = s; imm = im; start = 1'b1;
    @(posedge clk); n = 1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    chk({tag, " result"}, result, model(o, w, ui, d, s, im));
    chk({tag, " latency"}, 64'(n), 64'(exp_lat));
  endtask

  task automatic t_reset();
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset result", result, 64'd0);
  endtask

  task automatic t_arith();
    run("R2 add64 wrap", 4'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 1);
    run("R2 sub64", 4'd1, 1, 0, 64'd5, 64'd9, 0, 1);
    run("R1 mul64", 4'd2, 1, 0, 64'h1_0000_0003, 64'h2_0000_0005, 0, 1);
    run("R4 add32 carry dropped", 4'd0, 0, 0, 64'hAAAA_0000_FFFF_FFFF, 64'h5555_0000_0000_0001, 0, 1);
    run("R4 mul32", 4'd2, 0, 0, 64'h7777_0000_1234_5678, 64'h0000_0001_0000_1001, 0, 1);
    run("R1 undefined code", 4'd15, 0, 0, 64'hDEAD_BEEF_0BAD_F00D, 64'd1, 0, 1);
  endtask

  task automatic t_imm();
    run("R3 add64 neg imm", 4'd0, 1, 1, 64'd10, 64'd999, 32'hFFFF_FFFD, 1);
    run("R3 mov64 neg imm", 4'd12, 1, 1, 64'd0, 64'd7, 32'h8000_0000, 1);
    run("R3 mov32 neg imm", 4'd12, 0, 1, 64'h1234_5678_0000_0000, 64'd7, 32'hFFFF_FFFF, 1);
    run("R6 mov64 src", 4'd12, 1, 0, 64'd1, 64'hCAFE_0000_BEEF_0001, 0, 1);
  endtask

  task automatic t_logic();
    run("R1 and64", 4'd5, 1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 0, 1);
    run("R1 or32", 4'd6, 0, 0, 64'hFFFF_0000_0000_F000, 64'h0000_FFFF_0000_000F, 0, 1);
    run("R1 xor64 imm", 4'd7, 1, 1, 64'h0123_4567_89AB_CDEF, 0, 32'h8000_0001, 1);
  endtask

  task automatic t_shift();
    run("R5 shl64 count 65", 4'd8, 1, 0, 64'h8000_0000_0000_0001, 64'd65, 0, 1);
    run("R5 shl32 count 33", 4'd8, 0, 0, 64'hFFFF_FFFF_8000_0001, 64'd33, 0, 1);
    run("R5 shr64 neg", 4'd9, 1, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 1);
    run("R5 sar64 neg", 4'd10, 1, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 1);
    run("R5 sar32 bit31", 4'd10, 0, 1, 64'h0000_0001_8000_0010, 0, 32'd4, 1);
    run("R5 sar32 positive low", 4'd10, 0, 0, 64'hFFFF_FFFF_4000_0000, 64'd63, 0, 1);
  endtask

  task automatic t_neg();
    run("R6 neg64 ignores src", 4'd11, 1, 0, 64'd1, 64'h1234, 0, 1);
    run("R6 neg32", 4'd11, 0, 1, 64'hABCD_0000_0000_0001, 0, 32'h55, 1);
  endtask

  task automatic t_div();
    run("R7 div64", 4'd3, 1, 0, 64'hFEDC_BA98_7654_3210, 64'd1_000_003, 0, 65);
    run("R7 mod64", 4'd4, 1, 0, 64'hFEDC_BA98_7654_3210, 64'd1_000_003, 0, 65);
    run("R7 div64 big divisor", 4'd3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 0, 65);
    run("R8 div32", 4'd3, 0, 0, 64'h9999_0000_F000_0001, 64'h1_0000_0007, 0, 33);
    run("R8 mod32 imm", 4'd4, 0, 1, 64'h0000_0000_FFFF_FFFF, 0, 32'd10, 33);
  endtask

  task automatic t_divzero();
    run("R9 div64 by zero", 4'd3, 1, 0, 64'h1234, 64'd0, 0, 1);
    run("R9 mod64 by zero", 4'd4, 1, 1, 64'hDEAD_BEEF_0000_1234, 0, 32'd0, 1);
    run("R9 div32 masked zero", 4'd3, 0, 0, 64'h1234, 64'h1_0000_0000, 0, 1);
    run("R9 mod32 by zero", 4'd4, 0, 0, 64'hFFFF_0000_0000_4321, 64'h7_0000_0000, 0, 1);
  endtask

  // R11: request raised mid-division must not disturb it.
  task automatic t_busy();
    int ndone = 0, first = 0;
    logic [63:0] got = '0;
    logic [63:0] exp = model(4'd3, 1, 0, 64'd1_000_000_007, 64'd13, 0);
    @(negedge clk);
    op = 4'd3; wide = 1; use_imm = 0; dst_val = 64'd1_000_000_007; src_val = 64'd13; start = 1'b1;
    for (int i = 1; i <= 70; i++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (i == 10) begin
        op = 4'd0; wide = 0; dst_val = 64'd1; src_val = 64'd1; start = 1'b1;
      end
      if (done) begin
        ndone++;
        if (first == 0) begin first = i; got = result; end
      end
    end
    chk("R11 single completion", 64'(ndone), 64'd1);
    chk("R11 division edge count", 64'(first), 64'd65);
    chk("R11 pending quotient kept", got, exp);
    chk("R10 done dropped", 64'(done), 64'd0);
    chk("R10 result held", result, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_arith();
    t_imm();
    t_logic();
    t_shift();
    t_neg();
    t_div();
    t_divzero();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule